// File: doc/BRIEF.md
# Coin Vending Controller

This block is a small synchronous controller that collects nickels and dimes through one coin slot and releases an item once 15 cents has been paid. Each coin arrives as a single-cycle pulse on its own input line. Credit is kept as one of four levels: 0, 5, 10 or 15 cents. A dime paid at 10 cents still lands on the 15-cent level, because the controller neither gives change nor keeps credit above 15 cents. Once the top level is reached the controller stays there until a synchronous reset clears it back to zero.

Two parameters pick the build variant. The first chooses the output timing. In registered (Moore) timing, the release line follows the stored credit and rises one clock after the paying coin. In combinational (Mealy) timing, the release line also rises during the very cycle of the coin that completes payment, and it is masked while reset is high. The second parameter chooses how the credit level is stored: a two-bit binary code or a four-flop one-hot vector. Both encodings give identical release behaviour.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A cycle with `rst` high puts the controller on the 0-cent level at the next clock edge, whatever coins are present in that cycle.
- R2: A cycle with neither coin input high leaves the credit level unchanged.
- R3: A nickel alone (`nickelIn`=1, `dimeIn`=0) raises credit by one step: 0 to 5, 5 to 10, 10 to 15.
- R4: A dime alone raises credit by two steps and saturates: 0 to 10, 5 to 15, 10 to 15 (no change returned).
- R5: Both coin inputs high in the same cycle is an invalid request, and the credit level stays as it was.
- R6: The 15-cent level is held against any coin input until reset.
- R7: With `MEALY_OUT`=0, `openOut` is high exactly when the stored credit is 15 cents, so it rises on the clock edge that stores the paying coin.
- R8: With `MEALY_OUT`=1, `openOut` is high while `rst` is low and either the stored credit is 15 cents or the current cycle holds a valid coin that takes the credit from below 15 to 15. It is low in every cycle with `rst` high.
- R9: With `ONE_HOT`=1, the credit is held in four flops with exactly one set after reset, and `openOut` behaves identically to the binary build (`ONE_HOT`=0) for the same `MEALY_OUT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, returns credit to 0 cents |
| nickelIn | input | 1 | One-cycle pulse per 5-cent coin |
| dimeIn | input | 1 | One-cycle pulse per 10-cent coin |
| openOut | output | 1 | Drives the item release mechanism |

## Verification
Reset and a coin can occur in the same cycle, and so can a nickel and a dime. Reset is raised together with a nickel while the controller sits at 15 cents, and together with a dime while it sits at 10 cents. Reset must win in both cases: the credit returns to zero, and the combinational-output build keeps its release line low in that cycle even though the coin would otherwise complete payment. Paired coins are driven at several credit levels, and the credit is then probed by a single nickel to show whether it moved. All four parameter builds run side by side against one behavioural credit model, and every build's output is compared on every clock.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int unsigned NUM_LEVELS = 4;
  localparam int unsigned LVL_W      = $clog2(NUM_LEVELS);

  typedef enum logic [LVL_W-1:0] {
    CR0  = 2'd0,
    CR5  = 2'd1,
    CR10 = 2'd2,
    CR15 = 2'd3
  } credit_e;

  // Strobes from control to the credit datapath
  typedef struct packed {
    logic clear;
    logic addOne;
    logic addTwo;
  } stepStrobe_t;

endpackage

// File: rtl/vend_credit_path.sv
module vend_credit_path
  import vend_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic                  clk,
  input  stepStrobe_t           strobe,
  output credit_e               creditLvl,
  output logic                  atTop,
  output logic                  reachTop,
  output logic [NUM_LEVELS-1:0] stateBits
);

  localparam int unsigned TOP = NUM_LEVELS - 1;

  credit_e nextLvl;

  generate
    if (ONE_HOT) begin : g_onehot
      logic [NUM_LEVELS-1:0] hotQ;
      logic [NUM_LEVELS-1:0] hotD;
      logic [NUM_LEVELS-1:0] hotUp1;
      logic [NUM_LEVELS-1:0] hotUp2;

      // Saturating shifts: top bit collects everything pushed past it
      always_comb begin
        hotUp1 = {hotQ[NUM_LEVELS-2:0], 1'b0};
        hotUp1[TOP] = hotQ[TOP] | hotQ[TOP-1];
        hotUp2 = {hotQ[NUM_LEVELS-3:0], 2'b00};
        hotUp2[TOP] = hotQ[TOP] | hotQ[TOP-1] | hotQ[TOP-2];
      end

      always_comb begin
        if (strobe.clear) begin
          hotD    = '0;
          hotD[0] = 1'b1;
        end else if (strobe.addOne) begin
          hotD = hotUp1;
        end else if (strobe.addTwo) begin
          hotD = hotUp2;
        end else begin
          hotD = hotQ;
        end
      end

      always_ff @(posedge clk) begin
        hotQ <= hotD;
      end

      always_comb begin
        creditLvl = CR0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
          if (hotQ[i]) creditLvl = credit_e'(i);
        end
        nextLvl = CR0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
          if (hotD[i]) nextLvl = credit_e'(i);
        end
      end

      assign atTop     = hotQ[TOP];
      assign reachTop  = hotD[TOP] & ~hotQ[TOP];
      assign stateBits = hotQ;
    end else begin : g_binary
      credit_e binQ;
      logic [LVL_W:0] sum;

      always_comb begin
        sum = {1'b0, binQ} + {{LVL_W{1'b0}}, strobe.addOne}
                           + {{(LVL_W-1){1'b0}}, strobe.addTwo, 1'b0};
        if (strobe.clear) begin
          nextLvl = CR0;
        end else if (sum > (LVL_W+1)'(TOP)) begin
          nextLvl = CR15;
        end else begin
          nextLvl = credit_e'(sum[LVL_W-1:0]);
        end
      end

      always_ff @(posedge clk) begin
        binQ <= nextLvl;
      end

      assign creditLvl = binQ;
      assign atTop     = (binQ == CR15);
      assign reachTop  = (nextLvl == CR15) && (binQ != CR15);
      assign stateBits = {{(NUM_LEVELS-LVL_W){1'b0}}, binQ};
    end
  endgenerate

endmodule

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input  logic        rst,
  input  logic        nickelIn,
  input  logic        dimeIn,
  input  logic        atTop,
  input  logic        reachTop,
  output stepStrobe_t strobe,
  output logic        openOut
);

  logic coinValid;

  // A lone coin is valid; both together are refused
  assign coinValid     = nickelIn ^ dimeIn;
  assign strobe.clear  = rst;
  assign strobe.addOne = ~rst & coinValid & nickelIn;
  assign strobe.addTwo = ~rst & coinValid & dimeIn;

  generate
    if (MEALY_OUT) begin : g_mealy
      assign openOut = ~rst & (atTop | reachTop);
    end else begin : g_moore
      assign openOut = atTop;
    end
  endgenerate

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0,
  parameter bit ONE_HOT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic nickelIn,
  input  logic dimeIn,
  output logic openOut
);

  stepStrobe_t           strobe;
  credit_e               creditLvl;
  logic                  atTop;
  logic                  reachTop;
  logic [NUM_LEVELS-1:0] stateBits;

  vend_control #(.MEALY_OUT(MEALY_OUT)) u_ctrl (
    .rst      (rst),
    .nickelIn (nickelIn),
    .dimeIn   (dimeIn),
    .atTop    (atTop),
    .reachTop (reachTop),
    .strobe   (strobe),
    .openOut  (openOut)
  );

  vend_credit_path #(.ONE_HOT(ONE_HOT)) u_path (
    .clk       (clk),
    .strobe    (strobe),
    .creditLvl (creditLvl),
    .atTop     (atTop),
    .reachTop  (reachTop),
    .stateBits (stateBits)
  );

endmodule

// File: rtl/vend_checker.sv
module vend_checker
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0,
  parameter bit ONE_HOT   = 1'b0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  nickelIn,
  input logic                  dimeIn,
  input logic                  openOut,
  input credit_e               creditLvl,
  input logic [NUM_LEVELS-1:0] stateBits
);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> creditLvl == CR0);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!nickelIn && !dimeIn) |=> $stable(creditLvl));

  a_r3_nickel_step: assert property (@(posedge clk) disable iff (rst)
    (nickelIn && !dimeIn && creditLvl == CR5) |=> creditLvl == CR10);

  a_r4_dime_sat: assert property (@(posedge clk) disable iff (rst)
    (dimeIn && !nickelIn && creditLvl != CR0) |=> creditLvl == CR15);

  a_r5_pair_refused: assert property (@(posedge clk) disable iff (rst)
    (nickelIn && dimeIn) |=> $stable(creditLvl));

  a_r6_top_hold: assert property (@(posedge clk) disable iff (rst)
    (creditLvl == CR15) |=> creditLvl == CR15);

  a_r7_moore_open: assert property (@(posedge clk) disable iff (rst)
    (!MEALY_OUT) |-> (openOut == (creditLvl == CR15)));

  a_r8_mealy_arc: assert property (@(posedge clk) disable iff (rst)
    (MEALY_OUT && openOut && creditLvl != CR15) |=> creditLvl == CR15);

  a_r9_onehot_valid: assert property (@(posedge clk) disable iff (rst)
    (ONE_HOT && $past(rst)) |-> $onehot0(stateBits) && stateBits != '0);

endmodule

bind coin_vend_ctrl vend_checker #(.MEALY_OUT(MEALY_OUT), .ONE_HOT(ONE_HOT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .nickelIn  (nickelIn),
  .dimeIn    (dimeIn),
  .openOut   (openOut),
  .creditLvl (creditLvl),
  .stateBits (stateBits)
);

// File: tb/sim_coin_vend_ctrl.sv
module sim_coin_vend_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic openMooreBin, openMealyBin, openMooreHot, openMealyHot;

  int checks = 0;
  int fails  = 0;
  int cr     = 0;   // model credit in cents
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  coin_vend_ctrl #(.MEALY_OUT(1'b0), .ONE_HOT(1'b0)) u0 (
    .clk(clk), .rst(rst), .nickelIn(nickel), .dimeIn(dime), .openOut(openMooreBin));
  coin_vend_ctrl #(.MEALY_OUT(1'b1), .ONE_HOT(1'b0)) u1 (
    .clk(clk), .rst(rst), .nickelIn(nickel), .dimeIn(dime), .openOut(openMealyBin));
  coin_vend_ctrl #(.MEALY_OUT(1'b0), .ONE_HOT(1'b1)) u2 (
    .clk(clk), .rst(rst), .nickelIn(nickel), .dimeIn(dime), .openOut(openMooreHot));
  coin_vend_ctrl #(.MEALY_OUT(1'b1), .ONE_HOT(1'b1)) u3 (
    .clk(clk), .rst(rst), .nickelIn(nickel), .dimeIn(dime), .openOut(openMealyHot));

  task automatic check(input logic act, input logic exp, input string tag, input string who);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: openOut=%b expected %b (credit %0d)", tag, who, act, exp, cr);
    end
  endtask

  function automatic int nextCredit(input int c, input logic n, input logic d, input logic r);
    if (r) return 0;
    if (n && !d) return (c + 5 > 15) ? 15 : c + 5;
    if (d && !n) return (c + 10 > 15) ? 15 : c + 10;
    return c;
  endfunction

  task automatic step(input logic n, input logic d, input logic r, input string tag);
    int nx;
    logic expMoore, expMealy;
    @(negedge clk);
    nickel = n; dime = d; rst = r;
    #1;
    nx = nextCredit(cr, n, d, r);
    expMoore = (cr == 15);
    expMealy = !r && (cr == 15 || nx == 15);
    check(openMooreBin, expMoore, {tag, " R7"}, "moore/bin");
    check(openMealyBin, expMealy, {tag, " R8"}, "mealy/bin");
    check(openMooreHot, expMoore, {tag, " R9"}, "moore/hot");
    check(openMealyHot, expMealy, {tag, " R9"}, "mealy/hot");
    @(posedge clk);
    cr = nx;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lfsr;
    // untracked power-on reset
    repeat (2) @(posedge clk);
    cr = 0;
    step(0, 0, 1, "R1");
    // R2: idle at zero
    step(0, 0, 0, "R2");
    step(0, 0, 0, "R2");
    // R3: nickel ladder
    step(1, 0, 0, "R3");
    step(0, 0, 0, "R2");
    step(1, 0, 0, "R3");
    step(1, 0, 0, "R3");
    // R6: held at top against coins
    step(0, 0, 0, "R6");
    step(1, 0, 0, "R6");
    step(0, 1, 0, "R6");
    step(1, 1, 0, "R6");
    step(0, 0, 0, "R6");
    // R8/R1: reset with nickel at top
    step(1, 0, 1, "R1");
    step(0, 0, 0, "R1");
    // R4: dime 0->10->15
    step(0, 1, 0, "R4");
    step(0, 1, 0, "R4");
    step(0, 0, 0, "R4");
    step(0, 0, 1, "R1");
    // R4: 5 -> 15 by dime
    step(1, 0, 0, "R4");
    step(0, 1, 0, "R4");
    step(0, 0, 0, "R4");
    step(0, 0, 1, "R1");
    // R5: paired coins refused at 0, 5, 10
    step(1, 1, 0, "R5");
    step(0, 0, 0, "R5");
    step(1, 0, 0, "R5");
    step(1, 1, 0, "R5");
    step(1, 0, 0, "R5");
    step(1, 1, 0, "R5");
    step(1, 0, 0, "R5");
    step(0, 0, 0, "R5");
    // R8: reset with completing dime at 10
    step(0, 0, 1, "R1");
    step(0, 1, 0, "R8");
    step(0, 1, 1, "R8");
    step(0, 0, 0, "R8");
    step(1, 0, 0, "R8");
    // mixed pseudo-random traffic
    lfsr = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step(lfsr[0] & lfsr[3], lfsr[1] & lfsr[4], (lfsr[7:2] == 6'd0), "R2");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule